// File: doc/BRIEF.md
# Infrared Carrier Modulator Timer

This block drives an infrared emitter or a PWM load from a small set of control inputs. A power-of-two prescaler divides the system clock into a tick stream whose ratio is picked by a 3-bit code. Two 8-bit width values set the length of the two segments of the output waveform. The "space" segment is a plain high level. The "mark" segment is either a plain low level (PWM use) or a burst of a square-wave carrier (IR use). The carrier is made by a second divider of the tick stream and has a 50% duty cycle.

While the function is switched off, the output rests high and the timer counts ticks freely. When it is switched on, the block either repeats space and mark segments without end, or, in single-shot mode, emits one mark segment, returns to the high idle level and raises a done flag. Width values are taken at the start of each segment, so rewriting them while the block runs never shortens the segment in progress. A pin-ownership input routes either the modulator output or a general-purpose output value and enable onto the shared pad.

Top module: `ir_pulse_modulator`

## Requirements
- R1: The tick rate is one tick every 2^(scale_sel+1) clock cycles (code 0 gives 1:2, code 7 gives 1:256). The prescaler restarts from zero at reset and at every change of mod_en.
- R2: While mod_en is 0, ir_out is 1 in the same cycle. count_val restarts at 0 on the clock edge that sees mod_en change, advances by one on every tick and wraps from 255 to 0.
- R3: When mod_en rises with one_shot at 0, the block starts a space segment at that edge. A space segment of space_width ticks (ir_out 1) is followed by a mark segment of mark_width ticks, and the pair repeats. With ir_mode at 0, ir_out is 0 throughout a mark segment.
- R4: With ir_mode at 1, ir_out during a mark segment follows a carrier. The carrier is 1 for the first carrier_half ticks of the mark, then toggles every carrier_half ticks. It restarts from 1 at the start of every mark segment.
- R5: A width value of 0 means 256 ticks, and a carrier_half of 0 means 256 ticks.
- R6: space_width is read at the edge that starts a space segment, and mark_width at the edge that starts a mark segment. Changes at any other time affect only later segments.
- R7: When mod_en rises with one_shot at 1, the block emits exactly one mark segment of mark_width ticks, with space_width ignored. It then holds ir_out at 1 and sets shot_done. one_shot is read only at the rising edge of mod_en. shot_done clears at the next rising edge of mod_en.
- R8: With pin_sel at 1, pin_out equals ir_out and pin_oe is 1. With pin_sel at 0, pin_out equals gpio_out and pin_oe equals gpio_oe.
- R9: While enabled, count_val gives the number of ticks elapsed in the current segment, starting at 0. It returns to 0 at each segment boundary and stays 0 after a single shot completes. Dropping mod_en at any point returns ir_out high at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Modulator on (1) or off (0) |
| ir_mode | input | 1 | 1: carrier-modulated mark, 0: plain low mark |
| one_shot | input | 1 | 1: single mark then idle, read at enable rise |
| pin_sel | input | 1 | 1: pad driven by modulator, 0: general I/O |
| scale_sel | input | 3 | Prescaler ratio code, ratio 2^(code+1) |
| space_width | input | 8 | High segment length in ticks, 0 means 256 |
| mark_width | input | 8 | Mark segment length in ticks, 0 means 256 |
| carrier_half | input | 8 | Carrier half period in ticks, 0 means 256 |
| gpio_out | input | 1 | General I/O output value |
| gpio_oe | input | 1 | General I/O output enable |
| ir_out | output | 1 | Modulator output, idle high |
| pin_out | output | 1 | Shared pad output value |
| pin_oe | output | 1 | Shared pad output enable |
| count_val | output | 8 | Timer value (free count or ticks in segment) |
| shot_done | output | 1 | Single shot completed |

## Verification
ir_out, pin_out and pin_oe respond to mod_en, ir_mode, pin_sel and the general I/O inputs in the same cycle. Every segment change, carrier toggle and shot_done change is due on the rising edge that processes the last tick, and count_val moves on the edge that processes each tick. That edge comes 2^(scale_sel+1) clocks after the previous tick edge or after the enable edge. The bench keeps a cycle-level model, advanced on each rising edge from the requirements, of how many cycles have passed since the last enable change or segment start. It drives inputs on falling edges and compares every output a quarter period later, so both the same-cycle paths and the edge-timed results are checked in the cycle they are due.

// File: rtl/ircm_pkg.sv
package ircm_pkg;

   // Segment phase of the modulator
   typedef enum logic [1:0] {
      SEG_IDLE  = 2'd0,
      SEG_SPACE = 2'd1,
      SEG_MARK  = 2'd2,
      SEG_DONE  = 2'd3
   } seg_state_e;

endpackage

// File: rtl/ircm_prescaler.sv
module ircm_prescaler #(
   parameter int SCALE_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic [SCALE_W-1:0] scale_sel,
   output logic               tick
);

   localparam int NCODES = 1 << SCALE_W;
   localparam int PRE_W  = NCODES;

   logic [PRE_W-1:0]  pre_q;
   logic [NCODES-1:0] tick_vec;

   if (SCALE_W < 1 || SCALE_W > 4) begin : g_bad_scale
      $error("ircm_prescaler: SCALE_W must lie in 1..4");
   end

   // One terminal-count detector per ratio code
   for (genvar i = 0; i < NCODES; i++) begin : g_tc
      assign tick_vec[i] = &pre_q[i:0];
   end

   assign tick = tick_vec[scale_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (clear) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

endmodule

// File: rtl/ircm_carrier.sv
module ircm_carrier #(
   parameter int CARR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              advance,
   input  logic [CARR_W-1:0] half_period,
   output logic              carrier
);

   logic [CARR_W-1:0] ccnt_q;
   logic [CARR_W-1:0] half_m1;
   logic              carr_q;

   if (CARR_W < 2) begin : g_bad_carr
      $error("ircm_carrier: CARR_W must be at least 2");
   end

   // A zero half period wraps to the all-ones terminal count (2^CARR_W ticks)
   assign half_m1 = half_period - 1'b1;
   assign carrier = carr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ccnt_q <= '0;
         carr_q <= 1'b1;
      end else if (restart) begin
         ccnt_q <= '0;
         carr_q <= 1'b1;
      end else if (advance) begin
         if (ccnt_q == half_m1) begin
            ccnt_q <= '0;
            carr_q <= ~carr_q;
         end else begin
            ccnt_q <= ccnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ircm_segment_fsm.sv
module ircm_segment_fsm
   import ircm_pkg::*;
#(
   parameter int WIDTH_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               tick,
   input  logic               one_shot,
   input  logic [WIDTH_W-1:0] space_w,
   input  logic [WIDTH_W-1:0] mark_w,
   output seg_state_e         state,
   output logic [WIDTH_W-1:0] tmr,
   output logic               done,
   output logic               en_change,
   output logic               mark_start
);

   seg_state_e         state_q;
   logic [WIDTH_W-1:0] tmr_q;
   logic [WIDTH_W-1:0] cur_w_q;
   logic [WIDTH_W-1:0] w_m1;
   logic               en_q;
   logic               single_q;
   logic               done_q;
   logic               rise;
   logic               fall;
   logic               end_hit;

   if (WIDTH_W < 2) begin : g_bad_width
      $error("ircm_segment_fsm: WIDTH_W must be at least 2");
   end

   assign rise      = en & ~en_q;
   assign fall      = ~en & en_q;
   assign en_change = rise | fall;

   // Width 0 wraps to the all-ones terminal count (2^WIDTH_W ticks)
   assign w_m1    = cur_w_q - 1'b1;
   assign end_hit = tick && (tmr_q == w_m1);

   assign mark_start = (rise && one_shot) ||
                       (en && !rise && state_q == SEG_SPACE && end_hit);

   assign state = state_q;
   assign tmr   = tmr_q;
   assign done  = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         state_q  <= SEG_IDLE;
         tmr_q    <= '0;
         cur_w_q  <= '0;
         single_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         en_q <= en;
         if (rise) begin
            tmr_q    <= '0;
            done_q   <= 1'b0;
            single_q <= one_shot;
            if (one_shot) begin
               state_q <= SEG_MARK;
               cur_w_q <= mark_w;
            end else begin
               state_q <= SEG_SPACE;
               cur_w_q <= space_w;
            end
         end else if (!en) begin
            state_q <= SEG_IDLE;
            if (fall) begin
               tmr_q <= '0;
            end else if (tick) begin
               tmr_q <= tmr_q + 1'b1;
            end
         end else begin
            unique case (state_q)
               SEG_SPACE: begin
                  if (end_hit) begin
                     state_q <= SEG_MARK;
                     cur_w_q <= mark_w;
                     tmr_q   <= '0;
                  end else if (tick) begin
                     tmr_q <= tmr_q + 1'b1;
                  end
               end
               SEG_MARK: begin
                  if (end_hit) begin
                     tmr_q <= '0;
                     if (single_q) begin
                        state_q <= SEG_DONE;
                        done_q  <= 1'b1;
                     end else begin
                        state_q <= SEG_SPACE;
                        cur_w_q <= space_w;
                     end
                  end else if (tick) begin
                     tmr_q <= tmr_q + 1'b1;
                  end
               end
               default: begin
                  tmr_q <= tmr_q;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/ir_pulse_modulator.sv
module ir_pulse_modulator
   import ircm_pkg::*;
#(
   parameter int SCALE_W = 3,
   parameter int WIDTH_W = 8,
   parameter int CARR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mod_en,
   input  logic               ir_mode,
   input  logic               one_shot,
   input  logic               pin_sel,
   input  logic [SCALE_W-1:0] scale_sel,
   input  logic [WIDTH_W-1:0] space_width,
   input  logic [WIDTH_W-1:0] mark_width,
   input  logic [CARR_W-1:0]  carrier_half,
   input  logic               gpio_out,
   input  logic               gpio_oe,
   output logic               ir_out,
   output logic               pin_out,
   output logic               pin_oe,
   output logic [WIDTH_W-1:0] count_val,
   output logic               shot_done
);

   seg_state_e seg_state;
   logic       tick;
   logic       en_change;
   logic       mark_start;
   logic       carrier;
   logic       carr_adv;
   logic       seg_level;

   ircm_prescaler #(
      .SCALE_W (SCALE_W)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (en_change),
      .scale_sel (scale_sel),
      .tick      (tick)
   );

   ircm_segment_fsm #(
      .WIDTH_W (WIDTH_W)
   ) u_seg (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (mod_en),
      .tick       (tick),
      .one_shot   (one_shot),
      .space_w    (space_width),
      .mark_w     (mark_width),
      .state      (seg_state),
      .tmr        (count_val),
      .done       (shot_done),
      .en_change  (en_change),
      .mark_start (mark_start)
   );

   assign carr_adv = tick && (seg_state == SEG_MARK);

   ircm_carrier #(
      .CARR_W (CARR_W)
   ) u_carr (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (mark_start),
      .advance     (carr_adv),
      .half_period (carrier_half),
      .carrier     (carrier)
   );

   // Only the mark segment departs from the idle high level
   always_comb begin
      if (seg_state == SEG_MARK) begin
         seg_level = ir_mode & carrier;
      end else begin
         seg_level = 1'b1;
      end
   end

   assign ir_out  = mod_en ? seg_level : 1'b1;
   assign pin_out = pin_sel ? ir_out : gpio_out;
   assign pin_oe  = pin_sel | gpio_oe;

endmodule

// File: rtl/ircm_checker.sv
module ircm_checker #(
   parameter int WIDTH_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mod_en,
   input logic               pin_sel,
   input logic               ir_out,
   input logic               pin_out,
   input logic               pin_oe,
   input logic [WIDTH_W-1:0] count_val,
   input logic               shot_done
);

   // R2
   disabled_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_en |-> ir_out);

   // R2
   free_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !mod_en && !$past(mod_en) && !$past(mod_en, 2))
      |-> (count_val == $past(count_val) || count_val == $past(count_val) + 1'b1));

   // R7
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shot_done) |-> (ir_out && $past(mod_en)));

   // R7
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $fell(shot_done)) |-> ($past(mod_en) && !$past(mod_en, 2)));

   // R8
   pin_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_sel |-> (pin_oe && pin_out == ir_out));

endmodule

bind ir_pulse_modulator ircm_checker #(.WIDTH_W(WIDTH_W)) u_ircm_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mod_en    (mod_en),
   .pin_sel   (pin_sel),
   .ir_out    (ir_out),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .count_val (count_val),
   .shot_done (shot_done)
);

// File: tb/tb_ir_pulse_modulator.sv
module tb_ir_pulse_modulator;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       mod_en, ir_mode, one_shot, pin_sel, gpio_out, gpio_oe;
   logic [2:0] scale_sel;
   logic [7:0] space_width, mark_width, carrier_half;
   logic       ir_out, pin_out, pin_oe, shot_done;
   logic [7:0] count_val;

   int    n_chk  = 0;
   int    n_fail = 0;
   string cur_req = "R2";

   // Reference model state
   int m_c    = 0;   // cycles since reset or last enable change
   int m_seg  = 0;   // cycles into current segment
   int m_w    = 0;   // segment length in cycles
   int m_n    = 2;   // clocks per tick, fixed at each restart
   int m_st   = 0;   // 0 idle, 1 space, 2 mark, 3 done
   bit m_en   = 0;
   bit m_one  = 0;
   bit m_done = 0;

   always #(CLK_P/2) clk = ~clk;

   ir_pulse_modulator dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .mod_en       (mod_en),
      .ir_mode      (ir_mode),
      .one_shot     (one_shot),
      .pin_sel      (pin_sel),
      .scale_sel    (scale_sel),
      .space_width  (space_width),
      .mark_width   (mark_width),
      .carrier_half (carrier_half),
      .gpio_out     (gpio_out),
      .gpio_oe      (gpio_oe),
      .ir_out       (ir_out),
      .pin_out      (pin_out),
      .pin_oe       (pin_oe),
      .count_val    (count_val),
      .shot_done    (shot_done)
   );

   function automatic int effw(int w);
      return (w == 0) ? 256 : w;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Model advance on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_c = 0; m_seg = 0; m_st = 0; m_en = 0; m_done = 0;
         m_n = 2 << scale_sel;
      end else if (mod_en && !m_en) begin
         m_en = 1; m_c = 0; m_seg = 0; m_done = 0;
         m_n = 2 << scale_sel;
         m_one = one_shot;
         if (one_shot) begin
            m_st = 2; m_w = effw(int'(mark_width)) * m_n;
         end else begin
            m_st = 1; m_w = effw(int'(space_width)) * m_n;
         end
      end else if (!mod_en) begin
         if (m_en) begin
            m_c = 0; m_n = 2 << scale_sel;
         end else begin
            m_c++;
         end
         m_en = 0; m_st = 0; m_seg = 0;
      end else begin
         m_c++;
         if (m_st == 1 || m_st == 2) begin
            m_seg++;
            if (m_seg == m_w) begin
               m_seg = 0;
               if (m_st == 1) begin
                  m_st = 2; m_w = effw(int'(mark_width)) * m_n;
               end else if (m_one) begin
                  m_st = 3; m_done = 1;
               end else begin
                  m_st = 1; m_w = effw(int'(space_width)) * m_n;
               end
            end
         end
      end
   end

   // Compare every output a quarter period after the falling edge
   always @(negedge clk) begin
      int e_ir, e_cnt, h;
      #(CLK_P/4);
      h = effw(int'(carrier_half));
      e_ir = 1;
      if (mod_en && m_st == 2)
         e_ir = ir_mode ? ((((m_seg / m_n) / h) % 2) == 0) : 0;
      e_cnt = m_en ? (m_seg / m_n) : ((m_c / m_n) % 256);
      chk(cur_req, "ir_out", int'(ir_out), e_ir);
      chk(m_en ? "R9" : "R1", "count_val", int'(count_val), e_cnt);
      chk("R7", "shot_done", int'(shot_done), int'(m_done));
      chk("R8", "pin_out", int'(pin_out), pin_sel ? e_ir : int'(gpio_out));
      chk("R8", "pin_oe", int'(pin_oe), pin_sel ? 1 : int'(gpio_oe));
   end

   task automatic run(int cyc);
      repeat (cyc) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; mod_en = 0; ir_mode = 0; one_shot = 0; pin_sel = 0;
      gpio_out = 0; gpio_oe = 0; scale_sel = 3'd0;
      space_width = 8'd1; mark_width = 8'd1; carrier_half = 8'd1;
      run(3);
      rst_n = 1'b1;
      run(700);   // R1 R2: free count at 1:2 from reset, wraps past 255

      // R1 R2: every ratio code while disabled
      cur_req = "R2";
      for (int s = 0; s < 8; s++) begin
         scale_sel = 3'(s);
         mod_en = 1; run(1); mod_en = 0;
         run(600);
      end

      // R3: repeating PWM for several ratios and widths
      cur_req = "R3";
      ir_mode = 0;
      for (int s = 0; s < 3; s++)
         for (int hi = 1; hi <= 3; hi += 2)
            for (int lo = 1; lo <= 2; lo++) begin
               scale_sel = 3'(s); space_width = 8'(hi); mark_width = 8'(lo);
               mod_en = 1;
               run(3 * (hi + lo) * (2 << s) + 3);
               mod_en = 0; run(3);
            end

      // R4: carrier during mark
      cur_req = "R4";
      ir_mode = 1;
      for (int s = 0; s < 2; s++)
         for (int h = 1; h <= 3; h++) begin
            scale_sel = 3'(s); space_width = 8'd2; mark_width = 8'd7;
            carrier_half = 8'(h);
            mod_en = 1;
            run(2 * 9 * (2 << s) + 3);
            mod_en = 0; run(3);
         end

      // R5: zero widths and zero half period mean 256
      cur_req = "R5";
      ir_mode = 0; scale_sel = 3'd0; space_width = 8'd0; mark_width = 8'd1;
      mod_en = 1; run(2 * 257 * 2 + 5); mod_en = 0; run(3);
      ir_mode = 1; space_width = 8'd1; mark_width = 8'd0; carrier_half = 8'd0;
      mod_en = 1; run(2 * 257 * 2 + 5); mod_en = 0; run(3);
      carrier_half = 8'd100;
      mod_en = 1; run(257 * 2 + 5); mod_en = 0; run(3);

      // R6: width change mid-segment waits for the next boundary
      cur_req = "R6";
      ir_mode = 0; scale_sel = 3'd1; space_width = 8'd3; mark_width = 8'd2;
      mod_en = 1; run(2);
      space_width = 8'd5; mark_width = 8'd4;
      run(15);
      mark_width = 8'd1;
      run(60);
      mod_en = 0; run(3);

      // R7: single shot, space width ignored, one_shot read at rise only
      cur_req = "R7";
      one_shot = 1; mark_width = 8'd4; space_width = 8'd9; scale_sel = 3'd1;
      mod_en = 1; run(5);
      one_shot = 0; run(30);
      mod_en = 0; run(3);
      one_shot = 1; space_width = 8'd1; ir_mode = 1; carrier_half = 8'd1;
      mod_en = 1; run(30);
      mod_en = 0; run(3);
      one_shot = 0; ir_mode = 0;

      // R9: disable in the middle of a mark
      cur_req = "R9";
      scale_sel = 3'd2; space_width = 8'd1; mark_width = 8'd6;
      mod_en = 1; run(20);
      mod_en = 0; run(10);

      // R8: pad ownership under all control combinations
      cur_req = "R8";
      scale_sel = 3'd0; space_width = 8'd2; mark_width = 8'd3;
      mod_en = 1;
      for (int p = 0; p < 8; p++) begin
         {pin_sel, gpio_out, gpio_oe} = 3'(p);
         run(7);
      end
      mod_en = 0; run(4);

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule